// File: doc/BRIEF.md
# Masked-Write GPIO Bank with Primary-Function Muxing

This block is a bank of up to 32 general-purpose pins sitting between a hardware primary function and software control. A simple word-addressed register bus reaches direction, value and (optionally) mux registers. Every one of these registers carries its own write-enable mask in the upper half-word, so software can flip any subset of pins in one write without a read-modify-write cycle.

A build parameter picks one of three mux styles. With no muxing the pins are dedicated GPIOs. With per-pin muxing each pin has its own ownership bit. With whole-group muxing one coded register hands the entire bank to software or back to the primary function. Pins are grouped in slices of 16. The register map depends on the style, as listed in R3.

The pad input always goes straight back to the primary function. Software sees it through a two-flop synchronizer.

Top module: `gpio_mux_bank`

## Requirements
- R1: A write to a direction, value or pin-mux register changes data bit n (bits 15:0) only when mask bit 16+n of the same write is 1. All other bits keep their state.
- R2: A read of a direction or pin-mux register returns the stored bits in 15:0. Bits 31:16 read as zero, as do bits for pins beyond the bank width.
- R3: The word map is as follows. For per-pin style, slice s has direction at 3s, value at 3s+1 and pin-mux at 3s+2. For group style, the group register is at word 0, and slice s has direction at 1+2s and value at 2+2s. For no-mux style, slice s has direction at 2s and value at 2s+1. Pin p belongs to slice p/16 at bit p%16.
- R4: In GPIO mode a direction bit of 1 makes the pad drive: pad_oe equals the direction bit and pad_out equals the value bit.
- R5: When a pin is not in GPIO mode, pad_out and pad_oe follow prim_out and prim_oe. prim_in always equals pad_in.
- R6: In group style, writing 0x6 to the group register puts all pins in GPIO mode and writing 0x1 returns them to the primary function. Any other value is ignored. A read returns the current code, 0x6 or 0x1.
- R7: In no-mux style every pin is always in GPIO mode.
- R8: A value written while the pin is an input is driven on pad_out in the same cycle the direction bit turns to output.
- R9: A value-register read returns the stored value for output pins. For input pins it returns pad_in delayed by two clock edges.
- R10: After reset all direction, value and pin-mux bits are 0 and the group register reads 0x1.
- R11: Reads of unmapped words return zero. Writes to unmapped words change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data: mask in 31:16, values in 15:0 |
| bus_rdata | output | 32 | Read data for the current address |
| prim_out | input | NUM_PINS | Primary-function output levels |
| prim_oe | input | NUM_PINS | Primary-function output enables |
| prim_in | output | NUM_PINS | Pad levels returned to the primary function |
| pad_out | output | NUM_PINS | Pad output levels |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_in | input | NUM_PINS | Pad input levels |

## Verification
The bound checker watches several properties on every cycle:
- the mask rule on the first direction register, both the set and the hold cases;
- the zero upper half-word on masked reads;
- the zero result on unmapped reads;
- that the group state moves only after one of the two valid codes is written.

The bench scenarios cover the behaviour that needs a sequence of writes to show. This includes the value preloaded before a pin becomes an output and the two-edge latency of input readback. It also covers the ownership swap between primary function and software in all three mux styles, pins in the second slice, and ignored writes to unmapped words.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int STYLE_NONE  = 0;
   localparam int STYLE_PIN   = 1;
   localparam int STYLE_GROUP = 2;

   localparam logic [31:0] GRP_CODE_GPIO = 32'h0000_0006;
   localparam logic [31:0] GRP_CODE_PRIM = 32'h0000_0001;

   localparam int SLICE_PINS = 16;

   typedef enum logic [2:0] {
      REG_NONE = 3'd0,
      REG_GRP  = 3'd1,
      REG_DIR  = 3'd2,
      REG_VAL  = 3'd3,
      REG_PMUX = 3'd4
   } reg_kind_e;

   function automatic int set_stride(int style);
      return (style == STYLE_PIN) ? 3 : 2;
   endfunction

   function automatic int lead_words(int style);
      return (style == STYLE_GROUP) ? 1 : 0;
   endfunction

   function automatic int slice_count(int pins);
      return (pins + SLICE_PINS - 1) / SLICE_PINS;
   endfunction

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
   import gpio_bank_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int MUX_STYLE = STYLE_PIN,
   parameter int SLICES    = 2,
   parameter int SLICE_W   = 1
) (
   input  logic [ADDR_W-1:0]  addr,
   output reg_kind_e          kind,
   output logic [SLICE_W-1:0] slice
);
   localparam int BASE   = lead_words(MUX_STYLE);
   localparam int STRIDE = set_stride(MUX_STYLE);
   localparam int SPAN   = SLICES * STRIDE;

   always_comb begin
      int a;
      int off;
      a     = int'(addr);
      off   = a - BASE;
      kind  = REG_NONE;
      slice = '0;
      if (MUX_STYLE == STYLE_GROUP && a == 0) begin
         kind = REG_GRP;
      end else if (off >= 0 && off < SPAN) begin
         slice = SLICE_W'(off / STRIDE);
         case (off % STRIDE)
            0:       kind = REG_DIR;
            1:       kind = REG_VAL;
            default: kind = REG_PMUX;
         endcase
      end
   end
endmodule

// File: rtl/gpio_mask_reg.sv
module gpio_mask_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wmask,
   input  logic [W-1:0] wbits,
   output logic [W-1:0] q
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 q[i] <= 1'b0;
            else if (wr_en && wmask[i]) q[i] <= wbits[i];
         end
      end
   endgenerate
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= '0;
         q    <= '0;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/gpio_mux_bank.sv
module gpio_mux_bank
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS  = 20,
   parameter int MUX_STYLE = STYLE_PIN,
   parameter int ADDR_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] prim_out,
   input  logic [NUM_PINS-1:0] prim_oe,
   output logic [NUM_PINS-1:0] prim_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   input  logic [NUM_PINS-1:0] pad_in
);
   localparam int SLICES    = slice_count(NUM_PINS);
   localparam int SLICE_W   = (SLICES > 1) ? $clog2(SLICES) : 1;
   localparam int SLOTS     = 2 ** SLICE_W;
   localparam int MAP_WORDS = lead_words(MUX_STYLE) + SLICES * set_stride(MUX_STYLE);

   generate
      if (NUM_PINS < 1 || NUM_PINS > 32) begin : g_bad_pins
         $error("gpio_mux_bank: NUM_PINS must be 1..32");
      end
      if (MUX_STYLE < STYLE_NONE || MUX_STYLE > STYLE_GROUP) begin : g_bad_style
         $error("gpio_mux_bank: MUX_STYLE must be 0, 1 or 2");
      end
      if (MAP_WORDS > 2 ** ADDR_W) begin : g_bad_addr
         $error("gpio_mux_bank: ADDR_W too narrow for the register map");
      end
   endgenerate

   reg_kind_e          kind;
   logic [SLICE_W-1:0] slice;
   logic [NUM_PINS-1:0] dir_all, val_all, pmux_all, pad_sync, gpio_mode;
   logic                grp_gpio;
   logic [15:0]         dir_rd  [SLOTS];
   logic [15:0]         val_rd  [SLOTS];
   logic [15:0]         pmux_rd [SLOTS];

   gpio_bank_decode #(
      .ADDR_W(ADDR_W), .MUX_STYLE(MUX_STYLE), .SLICES(SLICES), .SLICE_W(SLICE_W)
   ) u_dec (
      .addr(bus_addr), .kind(kind), .slice(slice)
   );

   gpio_sync2 #(.W(NUM_PINS)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
   );

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slice
         if (s < SLICES) begin : g_live
            localparam int LO = s * SLICE_PINS;
            localparam int W  = (NUM_PINS - LO > SLICE_PINS) ? SLICE_PINS : NUM_PINS - LO;
            logic [W-1:0] dir_q, val_q;
            logic         hit;
            assign hit = bus_we && (int'(slice) == s);

            gpio_mask_reg #(.W(W)) u_dir (
               .clk(clk), .rst_n(rst_n), .wr_en(hit && kind == REG_DIR),
               .wmask(bus_wdata[16 +: W]), .wbits(bus_wdata[0 +: W]), .q(dir_q)
            );
            gpio_mask_reg #(.W(W)) u_val (
               .clk(clk), .rst_n(rst_n), .wr_en(hit && kind == REG_VAL),
               .wmask(bus_wdata[16 +: W]), .wbits(bus_wdata[0 +: W]), .q(val_q)
            );
            assign dir_all[LO +: W] = dir_q;
            assign val_all[LO +: W] = val_q;
            assign dir_rd[s]        = 16'(dir_q);
            assign val_rd[s]        = 16'((dir_q & val_q) | (~dir_q & pad_sync[LO +: W]));

            if (MUX_STYLE == STYLE_PIN) begin : g_pmux
               logic [W-1:0] pmux_q;
               gpio_mask_reg #(.W(W)) u_pmux (
                  .clk(clk), .rst_n(rst_n), .wr_en(hit && kind == REG_PMUX),
                  .wmask(bus_wdata[16 +: W]), .wbits(bus_wdata[0 +: W]), .q(pmux_q)
               );
               assign pmux_all[LO +: W] = pmux_q;
               assign pmux_rd[s]        = 16'(pmux_q);
            end else begin : g_no_pmux
               assign pmux_all[LO +: W] = '0;
               assign pmux_rd[s]        = '0;
            end
         end else begin : g_pad
            assign dir_rd[s]  = '0;
            assign val_rd[s]  = '0;
            assign pmux_rd[s] = '0;
         end
      end

      if (MUX_STYLE == STYLE_GROUP) begin : g_grp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) grp_gpio <= 1'b0;
            else if (bus_we && kind == REG_GRP) begin
               if (bus_wdata == GRP_CODE_GPIO)      grp_gpio <= 1'b1;
               else if (bus_wdata == GRP_CODE_PRIM) grp_gpio <= 1'b0;
            end
         end
         assign gpio_mode = {NUM_PINS{grp_gpio}};
      end else if (MUX_STYLE == STYLE_PIN) begin : g_pin
         assign grp_gpio  = 1'b0;
         assign gpio_mode = pmux_all;
      end else begin : g_none
         assign grp_gpio  = 1'b0;
         assign gpio_mode = '1;
      end
   endgenerate

   always_comb begin
      case (kind)
         REG_GRP:  bus_rdata = grp_gpio ? GRP_CODE_GPIO : GRP_CODE_PRIM;
         REG_DIR:  bus_rdata = {16'h0000, dir_rd[slice]};
         REG_VAL:  bus_rdata = {16'h0000, val_rd[slice]};
         REG_PMUX: bus_rdata = {16'h0000, pmux_rd[slice]};
         default:  bus_rdata = '0;
      endcase
   end

   assign pad_out = (gpio_mode & val_all) | (~gpio_mode & prim_out);
   assign pad_oe  = (gpio_mode & dir_all) | (~gpio_mode & prim_oe);
   assign prim_in = pad_in;

endmodule

// File: rtl/gpio_mux_bank_chk.sv
module gpio_mux_bank_chk #(
   parameter int NUM_PINS  = 20,
   parameter int MUX_STYLE = 1,
   parameter int ADDR_W    = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_we,
   input logic [31:0]         bus_wdata,
   input logic [31:0]         bus_rdata,
   input logic [NUM_PINS-1:0] dir_all,
   input logic                grp_gpio
);
   localparam int BASE      = (MUX_STYLE == 2) ? 1 : 0;
   localparam int STRIDE    = (MUX_STYLE == 1) ? 3 : 2;
   localparam int MAP_WORDS = BASE + ((NUM_PINS + 15) / 16) * STRIDE;

   logic dir0_wr;
   assign dir0_wr = bus_we && (int'(bus_addr) == BASE);

   // R1: a set mask bit loads the data bit
   a_r1_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      dir0_wr && bus_wdata[16] |=> dir_all[0] == $past(bus_wdata[0]));

   // R1: a clear mask bit keeps the old state
   a_r1_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      dir0_wr && !bus_wdata[16] |=> $stable(dir_all[0]));

   // R2: masked reads carry no upper half-word
   a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      int'(bus_addr) == BASE |-> bus_rdata[31:16] == 16'h0000);

   // R11: unmapped words read zero
   a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      int'(bus_addr) >= MAP_WORDS |-> bus_rdata == 32'h0);

   // R6: group ownership moves only on a valid code
   a_r6_group_codes: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(grp_gpio) |-> $past(bus_we && bus_addr == '0 &&
                                   (bus_wdata == 32'h6 || bus_wdata == 32'h1)));
endmodule

bind gpio_mux_bank gpio_mux_bank_chk #(
   .NUM_PINS(NUM_PINS), .MUX_STYLE(MUX_STYLE), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dir_all(dir_all),
   .grp_gpio(grp_gpio)
);

// File: tb/sim_gpio_mux_bank.sv
module sim_gpio_mux_bank;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [3:0]  addr  [3];
   logic        we    [3];
   logic [31:0] wdata [3];
   logic [31:0] rdata [3];

   logic [19:0] a_prim_out = 20'hA5A5A, a_prim_oe = 20'h0F0F0, a_pad_in = '0;
   logic [19:0] a_prim_in, a_pad_out, a_pad_oe;
   logic [19:0] b_prim_out = '0, b_prim_oe = '0, b_pad_in = '0;
   logic [19:0] b_prim_in, b_pad_out, b_pad_oe;
   logic [7:0]  c_prim_out = '0, c_prim_oe = '0, c_pad_in = '0;
   logic [7:0]  c_prim_in, c_pad_out, c_pad_oe;

   int n_chk = 0;
   int n_fail = 0;

   gpio_mux_bank #(.NUM_PINS(20), .MUX_STYLE(1), .ADDR_W(4)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr[0]), .bus_we(we[0]),
      .bus_wdata(wdata[0]), .bus_rdata(rdata[0]), .prim_out(a_prim_out),
      .prim_oe(a_prim_oe), .prim_in(a_prim_in), .pad_out(a_pad_out),
      .pad_oe(a_pad_oe), .pad_in(a_pad_in));

   gpio_mux_bank #(.NUM_PINS(20), .MUX_STYLE(2), .ADDR_W(4)) u1 (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr[1]), .bus_we(we[1]),
      .bus_wdata(wdata[1]), .bus_rdata(rdata[1]), .prim_out(b_prim_out),
      .prim_oe(b_prim_oe), .prim_in(b_prim_in), .pad_out(b_pad_out),
      .pad_oe(b_pad_oe), .pad_in(b_pad_in));

   gpio_mux_bank #(.NUM_PINS(8), .MUX_STYLE(0), .ADDR_W(4)) u2 (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr[2]), .bus_we(we[2]),
      .bus_wdata(wdata[2]), .bus_rdata(rdata[2]), .prim_out(c_prim_out),
      .prim_oe(c_prim_oe), .prim_in(c_prim_in), .pad_out(c_pad_out),
      .pad_oe(c_pad_oe), .pad_in(c_pad_in));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(int d, logic [3:0] a, logic [31:0] v);
      @(negedge clk);
      addr[d] = a; wdata[d] = v; we[d] = 1'b1;
      @(negedge clk);
      we[d] = 1'b0;
   endtask

   task automatic rd(int d, logic [3:0] a, output logic [31:0] v);
      addr[d] = a;
      #1;
      v = rdata[d];
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(0, 4'd0, v); chk("R10 dir0 reset", v, 32'h0);
      rd(0, 4'd2, v); chk("R10 pmux0 reset", v, 32'h0);
      rd(0, 4'd1, v); chk("R10 val0 reset", v, 32'h0);
      rd(1, 4'd0, v); chk("R10 group reset code", v, 32'h1);
      chk("R5 pad_oe follows primary", 32'(a_pad_oe), 32'(a_prim_oe));
      chk("R5 pad_out follows primary", 32'(a_pad_out), 32'(a_prim_out));
   endtask

   task automatic t_masked();
      logic [31:0] v;
      wr(0, 4'd0, 32'h0003_00FF);
      rd(0, 4'd0, v); chk("R1 masked set", v, 32'h0000_0003);
      wr(0, 4'd0, 32'h0001_FFFE);
      rd(0, 4'd0, v); chk("R1 masked clear one bit", v, 32'h0000_0002);
      chk("R2 upper half zero", {16'h0, v[31:16]}, 32'h0);
      wr(0, 4'd3, 32'hFFFF_FFFF);
      rd(0, 4'd3, v); chk("R2 slice1 width limit", v, 32'h0000_000F);
      wr(0, 4'd3, 32'hFFFF_0000);
   endtask

   task automatic t_pinmux();
      wr(0, 4'd1, 32'h0002_0002);
      chk("R5 pin1 primary before mux", 32'(a_pad_oe[1]), 32'(a_prim_oe[1]));
      wr(0, 4'd2, 32'h0002_0002);
      chk("R4 pin1 oe in gpio mode", 32'(a_pad_oe[1]), 32'h1);
      chk("R4 pin1 out in gpio mode", 32'(a_pad_out[1]), 32'h1);
      chk("R5 pin2 still primary", 32'(a_pad_out[2]), 32'(a_prim_out[2]));
      a_pad_in[5] = 1'b1; #1;
      chk("R5 prim_in mirrors pad", 32'(a_prim_in[5]), 32'h1);
      a_pad_in[5] = 1'b0;
   endtask

   task automatic t_preload();
      wr(0, 4'd2, 32'h0001_0001);
      wr(0, 4'd1, 32'h0001_0001);
      chk("R8 input pin not driven", 32'(a_pad_oe[0]), 32'h0);
      wr(0, 4'd0, 32'h0001_0001);
      chk("R8 preload oe", 32'(a_pad_oe[0]), 32'h1);
      chk("R8 preload value", 32'(a_pad_out[0]), 32'h1);
   endtask

   task automatic t_slice1();
      wr(0, 4'd5, 32'h0002_0002);
      wr(0, 4'd3, 32'h0002_0002);
      wr(0, 4'd4, 32'h0002_0002);
      chk("R3 pin17 oe via slice1", 32'(a_pad_oe[17]), 32'h1);
      chk("R3 pin17 out via slice1", 32'(a_pad_out[17]), 32'h1);
      chk("R3 pin1 unaffected by slice1", 32'(a_pad_oe[1]), 32'h1);
   endtask

   task automatic t_readback();
      logic [31:0] v;
      @(negedge clk);
      a_pad_in[3] = 1'b1;
      @(negedge clk);
      rd(0, 4'd1, v); chk("R9 sync first edge", 32'(v[3]), 32'h0);
      @(negedge clk);
      rd(0, 4'd1, v); chk("R9 sync second edge", 32'(v[3]), 32'h1);
      chk("R9 output pin reads stored", 32'(v[1]), 32'h1);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      wr(0, 4'd6, 32'hFFFF_FFFF);
      wr(0, 4'd15, 32'hFFFF_0000);
      rd(0, 4'd6, v);  chk("R11 unmapped read", v, 32'h0);
      rd(0, 4'd15, v); chk("R11 top word read", v, 32'h0);
      rd(0, 4'd0, v);  chk("R11 dir0 untouched", v, 32'h0000_0003);
      rd(0, 4'd2, v);  chk("R11 pmux0 untouched", v, 32'h0000_0003);
      chk("R11 pin1 still driven", 32'(a_pad_out[1]), 32'h1);
   endtask

   task automatic t_group();
      logic [31:0] v;
      wr(1, 4'd1, 32'h0001_0001);
      wr(1, 4'd2, 32'h0001_0001);
      wr(1, 4'd3, 32'h0004_0004);
      chk("R6 primary owns pin0", 32'(b_pad_oe[0]), 32'h0);
      wr(1, 4'd0, 32'h6);
      rd(1, 4'd0, v); chk("R6 group read gpio code", v, 32'h6);
      chk("R6 pin0 oe gpio", 32'(b_pad_oe[0]), 32'h1);
      chk("R6 pin0 out gpio", 32'(b_pad_out[0]), 32'h1);
      chk("R3 group pin18 via word3", 32'(b_pad_oe[18]), 32'h1);
      wr(1, 4'd0, 32'h5);
      rd(1, 4'd0, v); chk("R6 bad code ignored", v, 32'h6);
      chk("R6 pin0 kept after bad code", 32'(b_pad_oe[0]), 32'h1);
      wr(1, 4'd0, 32'h1);
      rd(1, 4'd0, v); chk("R6 group read primary code", v, 32'h1);
      chk("R6 pin0 returned to primary", 32'(b_pad_oe[0]), 32'h0);
   endtask

   task automatic t_none();
      logic [31:0] v;
      wr(2, 4'd0, 32'h0004_0004);
      wr(2, 4'd1, 32'h0004_0004);
      chk("R7 none style oe", 32'(c_pad_oe), 32'h04);
      chk("R7 none style out", 32'(c_pad_out), 32'h04);
      rd(2, 4'd2, v); chk("R11 none style no mux word", v, 32'h0);
   endtask

   initial begin
      for (int d = 0; d < 3; d++) begin
         addr[d] = '0; we[d] = 1'b0; wdata[d] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_masked();
      t_pinmux();
      t_preload();
      t_slice1();
      t_readback();
      t_unmapped();
      t_group();
      t_none();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule